// File: doc/BRIEF.md
# Fully Associative Page Translation Cache

This block keeps a small set of recent page mappings and turns a 32-bit virtual address into a 30-bit physical address within the same cycle. The upper 20 address bits are the virtual page number, and the lower 12 bits are the offset inside a 4 KB page. Any slot can hold any mapping. Every valid slot compares its stored page number against the request at the same time.

When a lookup misses, an external table walker loads the mapping through the fill port. If the walker finds that the page is not resident, it raises a flag with the fill. The block then installs nothing and reports a page fault one cycle later. A separate invalidate input empties the whole cache in one cycle.

Top module: `xlat_cache`

## Requirements
- R1: On a hit, `lk_paddr[11:0]` equals `lk_vaddr[11:0]`, and `lk_paddr[29:12]` is the stored physical page number of the slot whose tag equals `lk_vaddr[31:12]`.
- R2: `lk_hit` is high only when `lk_valid` is high and a valid slot holds the requested page number. When `lk_valid` is low, both `lk_hit` and `lk_miss` are low. `lk_paddr` is zero whenever `lk_hit` is low.
- R3: `lk_miss` is high in the same cycle as a request that finds no valid matching slot. Lookup results are combinational and reflect the contents as of the last clock edge.
- R4: A fill with `fl_absent` high installs nothing. It raises `fault` for exactly the following cycle. `fault` is low in every other cycle.
- R5: A fill with `fl_absent` low and `flush` low makes the mapping visible to lookups from the next cycle.
- R6: A fill whose page number is already held by a valid slot replaces the physical page in that slot and does not occupy a second slot.
- R7: A fill of a new page number goes into the lowest-numbered invalid slot.
- R8: When all slots are valid, a fill of a new page number evicts the slot named by a rotating pointer. The pointer starts at 0, advances by one only on such an eviction, and wraps after the last slot. `flush` leaves the pointer unchanged.
- R9: `flush` high clears every slot at the next edge. A fill in the same cycle is discarded, although its fault report (R4) still occurs.
- R10: Synchronous active-low reset clears every slot, sets the pointer to 0 and drives `fault` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Request made, no translation held |
| lk_paddr | output | 30 | Physical address (zero when not hit) |
| fl_valid | input | 1 | Fill request from the walker |
| fl_vpn | input | 20 | Virtual page number to install |
| fl_ppn | input | 18 | Physical page number to install |
| fl_absent | input | 1 | Walker found the page not resident |
| fault | output | 1 | Page fault, one cycle after an absent fill |
| flush | input | 1 | Invalidate all slots |

## Verification
The bench builds the block with four slots. This lets a short directed run fill the cache, force rotating evictions and wrap the pointer, all within a few dozen cycles. After the directed run, a random phase draws page numbers from a pool of seven. Because the pool is larger than the slot count, duplicate fills, evictions and repeat lookups all occur often. Flushes, absent fills and reset pulses are also scattered through the random phase.

// File: rtl/tlb_pkg.sv
// Shared address geometry for the page translation cache.
// Assumes 32-bit virtual addresses, 30-bit physical addresses, 4 KB pages.
package tlb_pkg;
    localparam int VA_W    = 32;
    localparam int PA_W    = 30;
    localparam int OFS_W   = 12;
    localparam int VPN_W   = VA_W - OFS_W;
    localparam int PPN_W   = PA_W - OFS_W;
endpackage

// File: rtl/tlb_store.sv
// Slot storage: valid bit, tag and physical page for each slot, plus the
// tag comparators for the lookup page and the fill page.
// Assumes at most one slot ever matches a given page (kept by the top).
module tlb_store
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int IDX_W     = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clear,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [VPN_W-1:0]                wr_vpn,
    input  logic [PPN_W-1:0]                wr_ppn,
    input  logic [VPN_W-1:0]                lk_vpn,
    output logic [N_ENTRIES-1:0]            valid_vec,
    output logic [N_ENTRIES-1:0]            look_match,
    output logic [N_ENTRIES-1:0]            fill_match,
    output logic [N_ENTRIES-1:0][PPN_W-1:0] ppn_tab
);
    logic [N_ENTRIES-1:0][VPN_W-1:0] tag_tab;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
        // Purpose: hold one slot; reset and clear drop the valid bit.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                valid_vec[g] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                valid_vec[g] <= 1'b1;
                tag_tab[g]   <= wr_vpn;
                ppn_tab[g]   <= wr_ppn;
            end
        end

        assign look_match[g] = valid_vec[g] && (tag_tab[g] == lk_vpn);
        assign fill_match[g] = valid_vec[g] && (tag_tab[g] == wr_vpn);
    end
endmodule

// File: rtl/tlb_victim.sv
// Picks the slot a fill writes: the slot already holding the page, else
// the lowest invalid slot, else the rotating pointer. Assumes fill_match
// is zero or one-hot.
module tlb_victim #(
    parameter int N_ENTRIES = 8,
    parameter int IDX_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit,
    input  logic [N_ENTRIES-1:0] valid_vec,
    input  logic [N_ENTRIES-1:0] fill_match,
    output logic [IDX_W-1:0]     wr_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] dup_idx;
    logic [IDX_W-1:0] free_idx;
    logic             dup_hit;
    logic             any_free;

    // Purpose: encode the one-hot duplicate vector into an index.
    always_comb begin
        dup_idx = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (fill_match[i]) dup_idx = dup_idx | IDX_W'(i);
        end
    end

    // Purpose: find the lowest-numbered invalid slot.
    always_comb begin
        free_idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) free_idx = IDX_W'(i);
        end
    end

    assign dup_hit  = |fill_match;
    assign any_free = ~&valid_vec;

    // Purpose: choose the write slot by priority.
    always_comb begin
        if (dup_hit)       wr_idx = dup_idx;
        else if (any_free) wr_idx = free_idx;
        else               wr_idx = rr_q;
    end

    // Purpose: advance the rotating pointer only on an eviction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (commit && !dup_hit && !any_free) begin
            rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_lookup.sv
// Combinational read side: reduces the match vector and selects the
// physical page by AND-OR over the one-hot match.
// Assumes look_match is zero or one-hot.
module tlb_lookup
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 8
) (
    input  logic                            lk_valid,
    input  logic [OFS_W-1:0]                lk_ofs,
    input  logic [N_ENTRIES-1:0]            look_match,
    input  logic [N_ENTRIES-1:0][PPN_W-1:0] ppn_tab,
    output logic                            lk_hit,
    output logic                            lk_miss,
    output logic [PA_W-1:0]                 lk_paddr
);
    logic [PPN_W-1:0] sel_ppn;

    // Purpose: AND-OR select of the matching physical page.
    always_comb begin
        sel_ppn = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            sel_ppn = sel_ppn | ({PPN_W{look_match[i]}} & ppn_tab[i]);
        end
    end

    assign lk_hit   = lk_valid && (|look_match);
    assign lk_miss  = lk_valid && !(|look_match);
    assign lk_paddr = lk_hit ? {sel_ppn, lk_ofs} : '0;
endmodule

// File: rtl/xlat_cache.sv
// Fully associative page translation cache. Lookup is combinational; fill,
// flush and reset act at the clock edge. Assumes the walker only fills
// after a miss and raises fl_absent for non-resident pages.
module xlat_cache
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic [PA_W-1:0]  lk_paddr,
    input  logic             fl_valid,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [PPN_W-1:0] fl_ppn,
    input  logic             fl_absent,
    output logic             fault,
    input  logic             flush
);
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

    logic                            commit;
    logic [IDX_W-1:0]                wr_idx;
    logic [N_ENTRIES-1:0]            valid_vec;
    logic [N_ENTRIES-1:0]            look_match;
    logic [N_ENTRIES-1:0]            fill_match;
    logic [N_ENTRIES-1:0][PPN_W-1:0] ppn_tab;

    assign commit = fl_valid && !fl_absent && !flush;

    tlb_store #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (flush),
        .wr_en      (commit),
        .wr_idx     (wr_idx),
        .wr_vpn     (fl_vpn),
        .wr_ppn     (fl_ppn),
        .lk_vpn     (lk_vaddr[VA_W-1:OFS_W]),
        .valid_vec  (valid_vec),
        .look_match (look_match),
        .fill_match (fill_match),
        .ppn_tab    (ppn_tab)
    );

    tlb_victim #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .valid_vec  (valid_vec),
        .fill_match (fill_match),
        .wr_idx     (wr_idx)
    );

    tlb_lookup #(.N_ENTRIES(N_ENTRIES)) u_lookup (
        .lk_valid   (lk_valid),
        .lk_ofs     (lk_vaddr[OFS_W-1:0]),
        .look_match (look_match),
        .ppn_tab    (ppn_tab),
        .lk_hit     (lk_hit),
        .lk_miss    (lk_miss),
        .lk_paddr   (lk_paddr)
    );

    // Purpose: one-cycle page fault report after an absent fill.
    always_ff @(posedge clk) begin
        if (!rst_n) fault <= 1'b0;
        else        fault <= fl_valid && fl_absent;
    end
endmodule

// File: rtl/xlat_cache_chk.sv
// Property checker for xlat_cache, attached by bind below.
module xlat_cache_chk #(
    parameter int N_ENTRIES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 lk_valid,
    input logic [31:0]          lk_vaddr,
    input logic                 lk_hit,
    input logic                 lk_miss,
    input logic [29:0]          lk_paddr,
    input logic                 fl_valid,
    input logic                 fl_absent,
    input logic                 fault,
    input logic                 flush,
    input logic [N_ENTRIES-1:0] look_match
);
    a_r1_offset_through: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_paddr[11:0] == lk_vaddr[11:0]);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_miss && lk_paddr == '0));

    a_r3_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (lk_hit != lk_miss));

    a_r4_fault_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && fl_absent) |=> fault);

    a_r4_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(fl_valid && fl_absent));

    a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(look_match) <= 1);

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);

    a_r10_reset_empties: assert property (@(posedge clk)
        !rst_n |=> (!lk_hit && !fault));
endmodule

bind xlat_cache xlat_cache_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_vaddr   (lk_vaddr),
    .lk_hit     (lk_hit),
    .lk_miss    (lk_miss),
    .lk_paddr   (lk_paddr),
    .fl_valid   (fl_valid),
    .fl_absent  (fl_absent),
    .fault      (fault),
    .flush      (flush),
    .look_match (look_match)
);

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit, lk_miss, fault;
    logic [29:0] lk_paddr;
    logic        fl_valid = 1'b0;
    logic [19:0] fl_vpn = '0;
    logic [17:0] fl_ppn = '0;
    logic        fl_absent = 1'b0;
    logic        flush = 1'b0;

    int checks = 0;
    int failures = 0;

    // behavioural reference state
    bit          m_v[N];
    int unsigned m_vpn[N];
    int unsigned m_ppn[N];
    int          m_rr = 0;
    bit          m_fault = 0;

    always #2.5 clk = ~clk;

    xlat_cache #(.N_ENTRIES(N)) uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
        .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_ppn(fl_ppn),
        .fl_absent(fl_absent), .fault(fault), .flush(flush)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive, compare with the model, advance the model.
    task automatic step(bit rst, bit lv, logic [31:0] va, bit fv,
                        logic [19:0] vpn, logic [17:0] ppn, bit abs_, bit fl);
        bit found;
        int idx;
        int unsigned hp;
        @(negedge clk);
        rst_n = rst; lk_valid = lv; lk_vaddr = va; fl_valid = fv;
        fl_vpn = vpn; fl_ppn = ppn; fl_absent = abs_; flush = fl;
        #1;
        found = 0; hp = 0;
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_vpn[i] == va[31:12]) begin found = 1; hp = m_ppn[i]; end
        if (rst_n) begin
            check("R2 hit", 32'(lk_hit), 32'(lv && found));
            check("R3 miss", 32'(lk_miss), 32'(lv && !found));
            check("R1 paddr", 32'(lk_paddr),
                  (lv && found) ? {2'b0, hp[17:0], va[11:0]} : 32'h0);
            check("R4 fault", 32'(fault), 32'(m_fault));
        end
        if (!rst) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
            m_rr = 0; m_fault = 0;
        end else begin
            m_fault = fv && abs_;
            if (fl) begin
                for (int i = 0; i < N; i++) m_v[i] = 0;
            end else if (fv && !abs_) begin
                idx = -1;
                for (int i = 0; i < N; i++)
                    if (m_v[i] && m_vpn[i] == vpn) idx = i;
                if (idx < 0)
                    for (int i = N - 1; i >= 0; i--) if (!m_v[i]) idx = i;
                if (idx < 0) begin idx = m_rr; m_rr = (m_rr + 1) % N; end
                m_v[idx] = 1; m_vpn[idx] = vpn; m_ppn[idx] = ppn;
            end
        end
    endtask

    task automatic fill(logic [19:0] vpn, logic [17:0] ppn);
        step(1, 0, 0, 1, vpn, ppn, 0, 0);
    endtask

    task automatic look(logic [19:0] vpn, logic [11:0] ofs);
        step(1, 1, {vpn, ofs}, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
        look(20'h00A11, 12'h123);
        check("R10 empty after reset", 32'(lk_miss), 32'h1);
        check("R10 fault low", 32'(fault), 32'h0);

        fill(20'h00A11, 18'h2BEEF);
        look(20'h00A11, 12'h5A5);
        check("R5 hit", 32'(lk_hit), 32'h1);
        check("R1 pa", 32'(lk_paddr), {2'b0, 18'h2BEEF, 12'h5A5});

        step(1, 0, 0, 1, 20'h00B22, 18'h1, 1, 0);
        look(20'h00B22, 12'h0);
        check("R4 fault pulse", 32'(fault), 32'h1);
        check("R4 nothing installed", 32'(lk_miss), 32'h1);
        look(20'h00B22, 12'h0);
        check("R4 pulse one cycle", 32'(fault), 32'h0);

        fill(20'h00A11, 18'h0C0DE);
        fill(20'h00C33, 18'h00003);
        fill(20'h00D44, 18'h00004);
        fill(20'h00E55, 18'h00005);
        look(20'h00A11, 12'hFFF);
        check("R6 overwrite in place", 32'(lk_paddr), {2'b0, 18'h0C0DE, 12'hFFF});
        look(20'h00E55, 12'h001);
        check("R7 fourth slot used", 32'(lk_hit), 32'h1);

        fill(20'h00F66, 18'h00006);
        look(20'h00A11, 12'h0);
        check("R8 pointer evicts slot 0", 32'(lk_miss), 32'h1);
        fill(20'h00177, 18'h00007);
        look(20'h00C33, 12'h0);
        check("R8 pointer evicts slot 1", 32'(lk_miss), 32'h1);
        look(20'h00D44, 12'h0);
        check("R8 slot 2 kept", 32'(lk_hit), 32'h1);
        fill(20'h00288, 18'h8);
        fill(20'h00399, 18'h9);
        fill(20'h004AA, 18'hA);
        look(20'h00F66, 12'h0);
        check("R8 pointer wraps to slot 0", 32'(lk_miss), 32'h1);

        step(1, 0, 0, 1, 20'h005BB, 18'hB, 0, 1);
        look(20'h005BB, 12'h0);
        check("R9 fill discarded under flush", 32'(lk_miss), 32'h1);
        look(20'h004AA, 12'h0);
        check("R9 all cleared", 32'(lk_miss), 32'h1);
        fill(20'h006CC, 18'hC);
        look(20'h006CC, 12'h0);
        check("R7 refill after flush", 32'(lk_hit), 32'h1);

        for (int c = 0; c < 600; c++) begin
            int r;
            r = $urandom % 100;
            step(r != 0, ($urandom % 4) != 0,
                 {20'h01000 + 20'($urandom % 7), 12'($urandom)},
                 ($urandom % 3) == 0, 20'h01000 + 20'($urandom % 7),
                 18'($urandom), ($urandom % 5) == 0, r < 3);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule